// File: doc/BRIEF.md
# Stream Cache Instruction Trace Compressor

The block shrinks an instruction address trace by replacing whole instruction streams with a short identifier. Each stream is described by a 32-bit start address and an 8-bit length, so a stream holds fewer than 256 instructions. Descriptors arrive one at a time over a valid/ready handshake, and each is looked up in a set-associative stream cache.

When the stream is already cached, only the cache position is sent out as a compact index: the set number above the way number. When the stream is not cached, the index output carries the reserved value zero. The full descriptor then goes out on a separate miss output, and the descriptor is written into a victim entry. Both outputs use valid/ready handshakes with holding registers.

A pulse on the task-switch input clears the cache contents. A mode input picks the victim policy, either a per-set rotating pointer or a tree pseudo-LRU.

Top module: `sc_trace_comp`

## Requirements
- R1: The set of a descriptor is `addr[5+n:6] XOR len[n-1:0]`, where n is log2 of the set count.
- R2: On a hit, one index transfer carries `{set, way}` (set in the upper bits) and no miss transfer is produced.
- R3: On a miss, one index transfer carries 0, and one miss transfer carries the same address and length that were presented.
- R4: Way 0 of set 0 is never filled, so index 0 is never produced by a hit. If either policy selects way 0 there, way 1 is used instead.
- R5: A lookup hits only a valid entry whose address and length both equal the descriptor's. A stream with the same address but a different length misses.
- R6: With `usePlru`=0, the victim is a per-set pointer. The pointer starts at way 1 in set 0 and at way 0 in every other set, and it advances by one on every fill of its set, wrapping around. In set 0 the wrap skips way 0.
- R7: With `usePlru`=1, each set keeps a tree of WAYS-1 bits numbered as a heap from node 1, with children 2k and 2k+1. A bit of 0 sends the victim search left and a bit of 1 sends it right, starting from the root. Every hit and every fill sets each node on the path to the used way so that it points away from that way. All bits start at 0.
- R8: A descriptor is accepted only while each output holding register is empty or is being emptied in the same cycle. An output that is not taken keeps its valid flag and its data unchanged.
- R9: A hit occupies the input for one cycle: its index is valid in the next cycle, and the input may accept again in that cycle. A miss occupies the input for two cycles: input ready is low in the cycle after acceptance, while the fill is done.
- R10: A `taskSwitch` pulse clears all valid bits and resets both replacement states to their initial values. No descriptor is accepted in that cycle, and a stream cached before the pulse misses after it.
- R11: After reset, `inReady` is 1 and both output valid flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| taskSwitch | input | 1 | One-cycle pulse that empties the cache |
| usePlru | input | 1 | Victim policy: 0 rotating pointer, 1 tree pseudo-LRU |
| inValid | input | 1 | Descriptor present |
| inReady | output | 1 | Descriptor accepted this cycle when high with inValid |
| inAddr | input | ADDR_W | Stream start address |
| inLen | input | LEN_W | Stream length |
| idxValid | output | 1 | Index output valid |
| idxReady | input | 1 | Index consumer ready |
| idxData | output | log2(SETS)+log2(WAYS) | `{set, way}` on a hit, 0 on a miss |
| missValid | output | 1 | Miss descriptor valid |
| missReady | input | 1 | Miss consumer ready |
| missAddr | output | ADDR_W | Start address of the missed stream |
| missLen | output | LEN_W | Length of the missed stream |

## Verification
The bench builds the block with 4 sets and 4 ways, a 32-bit address and an 8-bit length, so the index is 4 bits wide. With only 16 entries, a small pool of streams produces frequent evictions. Every pointer wrap and every path through the three-bit pseudo-LRU tree is reached within a few descriptors. Set 0 receives a quarter of the traffic, so the skip of its way 0 is exercised often, and random backpressure on both outputs drives the holding registers through their stall cases.

// File: rtl/sc_trace_pkg.sv
package sc_trace_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic accept;  // descriptor taken this cycle: look up, latch outputs
    logic fill;    // write the pending descriptor into the victim way
    logic clear;   // empty the cache and restart replacement state
  } scStrobe_t;

  typedef enum logic {ST_LOOK, ST_FILL} scState_t;

endpackage

// File: rtl/sc_trace_dp.sv
module sc_trace_dp
  import sc_trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  scStrobe_t         strobe,
  input  logic              usePlru,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LEN_W-1:0]  inLen,
  output logic              lookupHit,
  output logic [IDX_W-1:0]  idxData,
  output logic [ADDR_W-1:0] missAddr,
  output logic [LEN_W-1:0]  missLen,
  output logic [SET_W-1:0]  fillSet,
  output logic [WAY_W-1:0]  fillWay
);

  localparam logic [WAYS-2:0] TREE_ONE = 1;

  logic              entryValid [SETS][WAYS];
  logic [ADDR_W-1:0] entryAddr  [SETS][WAYS];
  logic [LEN_W-1:0]  entryLen   [SETS][WAYS];
  logic [WAY_W-1:0]  fifoPtr    [SETS];
  logic [WAYS-2:0]   plruBits   [SETS];

  logic [SET_W-1:0] lookupSet, pendSet;
  logic [WAY_W-1:0] hitWay, plruPick, ptrNext;

  // Walk the tree from the root; each bit names the half holding the victim.
  function automatic logic [WAY_W-1:0] plruVictim(input logic [WAYS-2:0] b);
    int node;
    logic [WAYS-2:0] t;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      t = b >> (node - 1);
      node = node * 2 + int'(t[0]);
    end
    return WAY_W'(node - WAYS);
  endfunction

  // Point every node on the path to way w away from it.
  function automatic logic [WAYS-2:0] plruTouch(input logic [WAYS-2:0] b,
                                               input logic [WAY_W-1:0] w);
    int node;
    logic [WAY_W-1:0] sh;
    logic [WAYS-2:0] m;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      sh = w >> (WAY_W - 1 - l);
      m = TREE_ONE << (node - 1);
      b = sh[0] ? (b & ~m) : (b | m);
      node = node * 2 + int'(sh[0]);
    end
    return b;
  endfunction

  assign lookupSet = inAddr[5+SET_W:6] ^ inLen[SET_W-1:0];
  assign fillSet   = pendSet;

  always_comb begin
    lookupHit = 1'b0;
    hitWay    = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!lookupHit && entryValid[lookupSet][w] &&
          entryAddr[lookupSet][w] == inAddr && entryLen[lookupSet][w] == inLen) begin
        lookupHit = 1'b1;
        hitWay    = WAY_W'(w);
      end
    end
  end

  always_comb begin
    plruPick = plruVictim(plruBits[pendSet]);
    if (pendSet == '0 && plruPick == '0) plruPick = WAY_W'(1);
    fillWay = usePlru ? plruPick : fifoPtr[pendSet];
    ptrNext = fifoPtr[pendSet] + WAY_W'(1);
    if (pendSet == '0 && ptrNext == '0) ptrNext = WAY_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) entryValid[s][w] <= 1'b0;
        fifoPtr[s]  <= (s == 0) ? WAY_W'(1) : WAY_W'(0);
        plruBits[s] <= '0;
      end
    end else if (strobe.accept) begin
      pendSet <= lookupSet;
      if (lookupHit) plruBits[lookupSet] <= plruTouch(plruBits[lookupSet], hitWay);
    end else if (strobe.fill) begin
      entryValid[pendSet][fillWay] <= 1'b1;
      entryAddr[pendSet][fillWay]  <= missAddr;
      entryLen[pendSet][fillWay]   <= missLen;
      plruBits[pendSet]            <= plruTouch(plruBits[pendSet], fillWay);
      fifoPtr[pendSet]             <= ptrNext;
    end
  end

  // Output holding registers; the miss registers double as the pending fill.
  always_ff @(posedge clk) begin
    if (rst) begin
      idxData  <= '0;
      missAddr <= '0;
      missLen  <= '0;
    end else if (strobe.accept) begin
      idxData <= lookupHit ? {lookupSet, hitWay} : '0;
      if (!lookupHit) begin
        missAddr <= inAddr;
        missLen  <= inLen;
      end
    end
  end

endmodule

// File: rtl/sc_trace_ctrl.sv
module sc_trace_ctrl
  import sc_trace_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      taskSwitch,
  input  logic      lookupHit,
  input  logic      idxReady,
  input  logic      missReady,
  output logic      inReady,
  output logic      idxValid,
  output logic      missValid,
  output scStrobe_t strobe
);

  scState_t state;
  logic idxFree, missFree, accept;

  assign idxFree  = !idxValid || idxReady;
  assign missFree = !missValid || missReady;
  assign inReady  = !rst && state == ST_LOOK && !taskSwitch && idxFree && missFree;
  assign accept   = inValid && inReady;

  always_comb begin
    strobe.accept = accept;
    strobe.fill   = state == ST_FILL && !taskSwitch;
    strobe.clear  = taskSwitch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOOK;
      idxValid  <= 1'b0;
      missValid <= 1'b0;
    end else begin
      if (taskSwitch)                state <= ST_LOOK;
      else if (accept && !lookupHit) state <= ST_FILL;
      else if (state == ST_FILL)     state <= ST_LOOK;

      if (accept)        idxValid <= 1'b1;
      else if (idxReady) idxValid <= 1'b0;

      if (accept && !lookupHit) missValid <= 1'b1;
      else if (missReady)       missValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sc_trace_comp.sv
module sc_trace_comp
  import sc_trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int IDX_W = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              taskSwitch,
  input  logic              usePlru,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [LEN_W-1:0]  inLen,
  output logic              idxValid,
  input  logic              idxReady,
  output logic [IDX_W-1:0]  idxData,
  output logic              missValid,
  input  logic              missReady,
  output logic [ADDR_W-1:0] missAddr,
  output logic [LEN_W-1:0]  missLen
);

  scStrobe_t        strobe;
  logic             lookupHit;
  logic             fillEn;
  logic [SET_W-1:0] fillSet;
  logic [WAY_W-1:0] fillWay;

  assign fillEn = strobe.fill;

  sc_trace_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .taskSwitch(taskSwitch),
    .lookupHit(lookupHit), .idxReady(idxReady), .missReady(missReady),
    .inReady(inReady), .idxValid(idxValid), .missValid(missValid), .strobe(strobe)
  );

  sc_trace_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SETS(SETS), .WAYS(WAYS)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .usePlru(usePlru),
    .inAddr(inAddr), .inLen(inLen), .lookupHit(lookupHit), .idxData(idxData),
    .missAddr(missAddr), .missLen(missLen), .fillSet(fillSet), .fillWay(fillWay)
  );

endmodule

// File: rtl/sc_trace_comp_chk.sv
module sc_trace_comp_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int SET_W  = 6,
  parameter int WAY_W  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    taskSwitch,
  input logic                    inValid,
  input logic                    inReady,
  input logic                    idxValid,
  input logic                    idxReady,
  input logic [SET_W+WAY_W-1:0]  idxData,
  input logic                    missValid,
  input logic                    missReady,
  input logic [ADDR_W-1:0]       missAddr,
  input logic [LEN_W-1:0]        missLen,
  input logic                    fillEn,
  input logic [SET_W-1:0]        fillSet,
  input logic [WAY_W-1:0]        fillWay
);

  p_idx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    idxValid && !idxReady |=> idxValid && $stable(idxData));

  p_miss_hold_r8: assert property (@(posedge clk) disable iff (rst)
    missValid && !missReady |=> missValid && $stable({missAddr, missLen}));

  p_miss_pair_r3: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> (missValid == (idxData == '0)));

  p_hit_latency_r9: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> idxValid);

  p_fill_stall_r9: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> (!missValid || !inReady));

  p_fill_follows_r9: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady |=> (!missValid || taskSwitch || fillEn));

  p_no_way0_r4: assert property (@(posedge clk) disable iff (rst)
    fillEn && fillSet == '0 |-> fillWay != '0);

endmodule

bind sc_trace_comp sc_trace_comp_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SET_W(SET_W), .WAY_W(WAY_W)
) u_chk (
  .clk(clk), .rst(rst), .taskSwitch(taskSwitch), .inValid(inValid), .inReady(inReady),
  .idxValid(idxValid), .idxReady(idxReady), .idxData(idxData),
  .missValid(missValid), .missReady(missReady), .missAddr(missAddr), .missLen(missLen),
  .fillEn(fillEn), .fillSet(fillSet), .fillWay(fillWay)
);

// File: tb/sc_trace_comp_bench.sv
`timescale 1ns/1ps
module sc_trace_comp_bench;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int SET_W  = 2;
  localparam int WAY_W  = 2;
  localparam int IDX_W  = SET_W + WAY_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, taskSwitch, usePlru, inValid, inReady, idxValid, idxReady, missValid, missReady;
  logic [ADDR_W-1:0] inAddr, missAddr;
  logic [LEN_W-1:0]  inLen, missLen;
  logic [IDX_W-1:0]  idxData;

  sc_trace_comp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SETS(SETS), .WAYS(WAYS)) u_sc_trace_comp (
    .clk(clk), .rst(rst), .taskSwitch(taskSwitch), .usePlru(usePlru),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inLen(inLen),
    .idxValid(idxValid), .idxReady(idxReady), .idxData(idxData),
    .missValid(missValid), .missReady(missReady), .missAddr(missAddr), .missLen(missLen)
  );

  int nChecks = 0, nBad = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nChecks++;
      nBad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  // ---------------- reference model built from the requirements ----------------
  bit                mValid [SETS][WAYS];
  logic [ADDR_W-1:0] mAddr  [SETS][WAYS];
  logic [LEN_W-1:0]  mLen   [SETS][WAYS];
  int                mPtr   [SETS];
  bit                mTree  [SETS][WAYS-1];
  int                expIdx[$];
  logic [39:0]       expMiss[$];
  int                lastIdx;
  bit                sReady, sIdxV, sMissV, sAcc;

  function automatic int setOf(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    return int'(((a >> 6) ^ ADDR_W'(l)) & (SETS - 1));  // R1
  endfunction

  function automatic logic [ADDR_W-1:0] mk(input int s, input int tag, input int l);
    return ADDR_W'((tag << 8) | (((s ^ l) & (SETS - 1)) << 6));
  endfunction

  task automatic modelClear();
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) mValid[s][w] = 0;
      for (int k = 0; k < WAYS - 1; k++) mTree[s][k] = 0;
      mPtr[s] = (s == 0) ? 1 : 0;
    end
  endtask

  task automatic touch(input int s, input int w);  // R7 update rule
    int node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      int dir = (w >> (WAY_W - 1 - l)) & 1;
      mTree[s][node-1] = (dir == 0);
      node = node * 2 + dir;
    end
  endtask

  task automatic modelAccept(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l);
    int s = setOf(a, l);
    int hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (hw < 0 && mValid[s][w] && mAddr[s][w] == a && mLen[s][w] == l) hw = w;  // R5
    if (hw >= 0) begin
      expIdx.push_back(s * WAYS + hw);  // R2
      touch(s, hw);
    end else begin
      int v;
      expIdx.push_back(0);  // R3
      expMiss.push_back({a, l});
      if (usePlru) begin
        int node = 1;
        for (int k = 0; k < WAY_W; k++) node = node * 2 + int'(mTree[s][node-1]);
        v = node - WAYS;
      end else v = mPtr[s];  // R6
      if (s == 0 && v == 0) v = 1;  // R4
      mValid[s][v] = 1;
      mAddr[s][v]  = a;
      mLen[s][v]   = l;
      touch(s, v);
      mPtr[s] = (mPtr[s] + 1) % WAYS;
      if (s == 0 && mPtr[s] == 0) mPtr[s] = 1;
    end
  endtask

  // One cycle, starting and ending just after a falling edge.
  task automatic step(input bit v, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                      input int rdy, input bit ts);
    inValid = v; inAddr = a; inLen = l; taskSwitch = ts;
    if (rdy == 0) begin idxReady = 1; missReady = 1; end
    else if (rdy == 1) begin idxReady = 0; missReady = 0; end
    else begin idxReady = ($urandom % 4) != 0; missReady = ($urandom % 4) != 0; end
    #1;
    sReady = inReady; sIdxV = idxValid; sMissV = missValid; sAcc = v && inReady;
    if (idxValid && idxReady) begin
      if (expIdx.size() == 0) check(0, "R2 R3 unexpected index", idxData, 0);
      else begin
        int e = expIdx.pop_front();
        check(idxData == IDX_W'(e), "R2 R3 index value", idxData, e);
      end
      lastIdx = int'(idxData);
    end
    if (missValid && missReady) begin
      if (expMiss.size() == 0) check(0, "R3 unexpected miss", missAddr, 0);
      else begin
        logic [39:0] em = expMiss.pop_front();
        check({missAddr, missLen} == em, "R3 miss descriptor", {missAddr, missLen}, em);
      end
    end
    if (ts) modelClear();
    if (sAcc) modelAccept(a, l);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l, input int rdy);
    int n = 0;
    do begin
      step(1, a, l, rdy, 0);
      n++;
    end while (!sAcc && n < 50);
    if (!sAcc) check(0, "R8 descriptor never accepted", 0, 1);
  endtask

  task automatic idle(input int rdy);
    step(0, '0, '0, rdy, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 30; i++)
      if (idxValid || missValid || expIdx.size() != 0) idle(0);
    check(expIdx.size() == 0 && expMiss.size() == 0, "R2 R3 all transfers delivered",
          expIdx.size() + expMiss.size(), 0);
  endtask

  task automatic tswitch(input bit plru);
    usePlru = plru;
    step(1, '0, '0, 0, 1);
    check(!sReady, "R10 no acceptance during clear", sReady, 0);
  endtask

  initial begin
    logic [ADDR_W-1:0] a0;
    void'($urandom(32'h5eed));
    rst = 1; taskSwitch = 0; usePlru = 0; inValid = 0; inAddr = '0; inLen = '0;
    idxReady = 1; missReady = 1;
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(inReady == 1, "R11 ready after reset", inReady, 1);
    check(idxValid == 0 && missValid == 0, "R11 outputs idle after reset",
          {idxValid, missValid}, 0);
    @(negedge clk);

    // First sight of a stream, then the miss timing (R3, R9)
    a0 = mk(0, 1, 5);
    send(a0, 5, 0);
    idle(0);
    check(sReady == 0, "R9 input held during fill", sReady, 0);
    check(sMissV == 1, "R3 miss output raised", sMissV, 1);
    idle(0);
    check(sReady == 1, "R9 input free after fill", sReady, 1);
    drain();
    check(lastIdx == 0, "R3 reserved index on miss", lastIdx, 0);

    // Hit: one-cycle turnaround, set 0 way 1 (R1 R4 R9)
    send(a0, 5, 0);
    idle(0);
    check(sIdxV == 1 && sReady == 1, "R9 hit in one clock", {sIdxV, sReady}, 2'b11);
    drain();
    check(lastIdx == 1, "R1 R4 hit index set0 way1", lastIdx, 1);

    // Same address, other length in the same set; other address (R5)
    send(a0, 9, 0); drain();
    check(lastIdx == 0, "R5 length must match", lastIdx, 0);
    send(mk(0, 2, 5), 5, 0); drain();
    check(lastIdx == 0, "R5 address must match", lastIdx, 0);

    // Backpressure (R8)
    send(a0, 5, 0);
    step(1, a0, 5, 1, 0);
    check(sReady == 0, "R8 input refused while index held", sReady, 0);
    step(1, a0, 5, 1, 0);
    check(sIdxV == 1 && idxData == IDX_W'(1), "R8 index held", idxData, 1);
    drain();

    // Task switch forgets everything (R10)
    tswitch(0);
    send(a0, 5, 0); drain();
    check(lastIdx == 0, "R10 cached stream misses after clear", lastIdx, 0);

    // Rotating pointer (R6): set 0 fills ways 1,2,3,1
    send(mk(0, 3, 5), 5, 0);
    send(mk(0, 4, 5), 5, 0);
    send(mk(0, 5, 5), 5, 0);
    drain();
    send(mk(0, 3, 5), 5, 0); drain();
    check(lastIdx == 2, "R6 second stream kept in way 2", lastIdx, 2);
    send(a0, 5, 0); drain();
    check(lastIdx == 0, "R6 oldest stream evicted", lastIdx, 0);
    send(mk(2, 1, 0), 0, 0); send(mk(2, 1, 0), 0, 0); drain();
    check(lastIdx == 8, "R6 other sets start at way 0", lastIdx, 8);

    // Tree pseudo-LRU (R7): set 1 fills ways 0,2,1,3
    tswitch(1);
    for (int k = 0; k < 4; k++) send(mk(1, 10 + k, 0), 0, 0);
    send(mk(1, 10, 0), 0, 0); drain();
    check(lastIdx == 4, "R7 first fill in way 0", lastIdx, 4);
    send(mk(1, 14, 0), 0, 0);
    send(mk(1, 12, 0), 0, 0); drain();
    check(lastIdx == 5, "R7 third fill in way 1 kept", lastIdx, 5);
    send(mk(1, 11, 0), 0, 0); drain();
    check(lastIdx == 0, "R7 way 2 chosen as victim", lastIdx, 0);
    send(mk(0, 20, 3), 3, 0); send(mk(0, 20, 3), 3, 0); drain();
    check(lastIdx == 1, "R4 R7 set 0 skips way 0", lastIdx, 1);

    // Random traffic with backpressure and policy changes
    for (int i = 0; i < 2500; i++) begin
      if (i % 500 == 499) begin
        drain();
        tswitch(1'($urandom % 2));
      end
      if ($urandom % 5 == 0) idle(2);
      else begin
        int s = $urandom % SETS;
        int t = $urandom % 3;
        int l = $urandom % 4;
        send(mk(s, t, l), LEN_W'(l), 2);
      end
    end
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule